// File: doc/BRIEF.md
# Dual-Thread Fetch PC Arbiter

This block is the fetch front end of a single-issue pipeline that carries a second, lightweight helper thread. It keeps one program counter for the main thread and one for the helper thread. Each cycle it uses one of them to address a shared instruction store. The pipeline-wide stall input picks the counter. While the whole pipeline is stalled for the main thread, the helper counter drives the fetch. The rest of the time the main counter does.

The instruction store has two fixed regions. The lower region belongs to the main thread and the upper region to the helper thread. A write port loads the store. Every fetched word is registered together with its address and a one-bit thread tag, so that later stages can steer the word to the right thread's resources.

Each thread has its own redirect input with a target address. A redirect changes only its own thread's counter, and it takes effect whether or not that thread is fetching in that cycle.

Top module: `dual_pc_fetch`

## Requirements
- R1: While `rst` is high, the main PC is set to 0 and the helper PC to `HELPER_BASE` (768). The registered outputs `fetch_addr`, `fetch_thread` and `fetch_word` read 0 during reset.
- R2: The store holds 2^`ADDR_W` (1024) words of `DATA_W` (46) bits, written through `load_en`/`load_addr`/`load_data`. One cycle after an address is fetched, `fetch_word` shows the content of that address.
- R3: In a cycle where `stall_all` is 1, the fetch address is the helper PC. In a cycle where it is 0, the fetch address is the main PC. The fetch address appears on `fetch_addr` one cycle later.
- R4: The PC that is not selected holds its value. The selected PC without a redirect advances by one entry per cycle.
- R5: The main PC never goes beyond `HELPER_BASE`-1 (767). Once it reaches that entry it stays there while it is selected.
- R6: When the helper PC advances from the last entry (1023), it wraps back to `HELPER_BASE` (768).
- R7: `fetch_thread` is registered with the word and the address. It is 0 for a main-thread fetch and 1 for a helper-thread fetch.
- R8: A redirect with a target inside its own thread's region loads that thread's PC on the next edge. This happens whether or not the thread is selected, and it has priority over advancing. The other thread's PC is unaffected.
- R9: When `stall_all` falls, the main thread fetches from the same PC it held when the stall began.
- R10: A redirect whose target lies outside its own thread's region is ignored. The PC behaves as if no redirect had been given.
- R11: If a load writes the address being fetched in the same cycle, `fetch_word` returns the previous content. The new content is returned on later fetches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stall_all | input | 1 | Pipeline-wide stall; selects the helper PC when 1 |
| main_redir_valid | input | 1 | Redirect request for the main PC |
| main_redir_target | input | ADDR_W | Redirect target for the main PC |
| helper_redir_valid | input | 1 | Redirect request for the helper PC |
| helper_redir_target | input | ADDR_W | Redirect target for the helper PC |
| load_en | input | 1 | Store write enable |
| load_addr | input | ADDR_W | Store write address |
| load_data | input | DATA_W | Store write data |
| fetch_word | output | DATA_W | Registered fetched word |
| fetch_addr | output | ADDR_W | Registered address of the fetched word |
| fetch_thread | output | 1 | Registered thread tag, 0 main, 1 helper |

## Verification
The assertions check on every cycle that each PC stays inside its region. They also check that an unselected PC without a redirect holds, that a selected PC steps, saturates or wraps as its region demands, that valid redirects are taken and out-of-region ones ignored, and that the registered tag always agrees with the region of the registered address. Other behaviours span the store and the thread switch, so only the bench's scenarios can show them. These are the word contents after loading, read-before-write on a colliding load, and the main thread resuming at its held PC after a stall. The bench covers them with directed cases and with random mixes of stalls, redirects and loads checked against its own model.

// File: rtl/fpa_pkg.sv
`timescale 1ns/1ps
package fpa_pkg;
    // Default geometry of the fetch front end
    localparam int FPA_ADDR_W      = 10;
    localparam int FPA_DATA_W      = 46;
    localparam int FPA_HELPER_BASE = 768;
    localparam int FPA_THREADS     = 2;

    // Thread tag carried with every fetched word
    typedef enum logic {
        THR_MAIN = 1'b0,
        THR_HELP = 1'b1
    } fpa_thread_e;
endpackage

// File: rtl/fpa_pc_slot.sv
`timescale 1ns/1ps
// One thread's program counter, confined to [BASE, LIMIT].
module fpa_pc_slot #(
    parameter int AW    = 10,
    parameter int BASE  = 0,
    parameter int LIMIT = 767,
    parameter bit WRAP  = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel_i,
    input  logic          redir_v_i,
    input  logic [AW-1:0] redir_tgt_i,
    output logic [AW-1:0] pc_o
);
    localparam logic [AW-1:0] BASE_A  = AW'(BASE);
    localparam logic [AW-1:0] LIMIT_A = AW'(LIMIT);

    typedef struct packed {
        logic [AW-1:0] pc;
    } slot_t;

    slot_t st_d, st_q;
    logic  tgt_ok;

    always_comb begin
        tgt_ok = (int'(redir_tgt_i) >= BASE) && (int'(redir_tgt_i) <= LIMIT);
        st_d   = st_q;
        if (redir_v_i && tgt_ok) begin
            st_d.pc = redir_tgt_i;
        end else if (sel_i) begin
            if (st_q.pc == LIMIT_A) begin
                st_d.pc = WRAP ? BASE_A : LIMIT_A;
            end else begin
                st_d.pc = st_q.pc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pc <= BASE_A;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o = st_q.pc;

    AST_PC_IN_REGION: assert property (@(posedge clk) disable iff (rst)
        (int'(pc_o) >= BASE) && (int'(pc_o) <= LIMIT)); // R5

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!sel_i && !redir_v_i) |=> $stable(pc_o)); // R4

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (sel_i && !redir_v_i && pc_o != LIMIT_A) |=> (pc_o == $past(pc_o) + 1'b1)); // R4

    AST_REGION_END: assert property (@(posedge clk) disable iff (rst)
        (sel_i && !redir_v_i && pc_o == LIMIT_A) |=> (pc_o == (WRAP ? BASE_A : LIMIT_A))); // R6

    AST_REDIR_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (redir_v_i && int'(redir_tgt_i) >= BASE && int'(redir_tgt_i) <= LIMIT)
        |=> (pc_o == $past(redir_tgt_i))); // R8

    AST_BAD_REDIR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (redir_v_i && !sel_i && (int'(redir_tgt_i) < BASE || int'(redir_tgt_i) > LIMIT))
        |=> $stable(pc_o)); // R10
endmodule

// File: rtl/fpa_istore.sv
`timescale 1ns/1ps
// Instruction store with one write port and one registered read port.
module fpa_istore #(
    parameter int AW    = 10,
    parameter int DW    = 46,
    parameter int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rd_addr_i,
    output logic [DW-1:0] rd_data_o,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i
);
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_d, rd_q;

    always_comb begin
        rd_d = mem[rd_addr_i];
    end

    // Write into the array (not reset, so the store can be loaded during reset)
    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem[wr_addr_i] <= wr_data_i;
        end
    end

    // Read register samples the old content on a colliding write
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data_o = rd_q;
endmodule

// File: rtl/fpa_fetch_sel.sv
`timescale 1ns/1ps
// Selects the fetching thread and registers address and tag.
module fpa_fetch_sel
    import fpa_pkg::*;
#(
    parameter int AW          = 10,
    parameter int HELPER_BASE = 768
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stall_all_i,
    input  logic [AW-1:0] pc_main_i,
    input  logic [AW-1:0] pc_help_i,
    output logic          sel_main_o,
    output logic          sel_help_o,
    output logic [AW-1:0] fetch_pc_o,
    output logic [AW-1:0] addr_o,
    output fpa_thread_e   tag_o
);
    typedef struct packed {
        logic [AW-1:0] addr;
        fpa_thread_e   tag;
    } meta_t;

    meta_t meta_d, meta_q;
    fpa_thread_e cur_thr;

    always_comb begin
        cur_thr     = stall_all_i ? THR_HELP : THR_MAIN;
        sel_main_o  = (cur_thr == THR_MAIN);
        sel_help_o  = (cur_thr == THR_HELP);
        fetch_pc_o  = sel_help_o ? pc_help_i : pc_main_i;
        meta_d.addr = fetch_pc_o;
        meta_d.tag  = cur_thr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q.addr <= '0;
            meta_q.tag  <= THR_MAIN;
        end else begin
            meta_q <= meta_d;
        end
    end

    assign addr_o = meta_q.addr;
    assign tag_o  = meta_q.tag;

    AST_HELP_TAG_REGION: assert property (@(posedge clk) disable iff (rst)
        (tag_o == THR_HELP) |-> (int'(addr_o) >= HELPER_BASE)); // R7

    AST_MAIN_TAG_REGION: assert property (@(posedge clk) disable iff (rst)
        (tag_o == THR_MAIN) |-> (int'(addr_o) < HELPER_BASE)); // R3
endmodule

// File: rtl/dual_pc_fetch.sv
`timescale 1ns/1ps
module dual_pc_fetch
    import fpa_pkg::*;
#(
    parameter int ADDR_W      = FPA_ADDR_W,
    parameter int DATA_W      = FPA_DATA_W,
    parameter int HELPER_BASE = FPA_HELPER_BASE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall_all,
    input  logic              main_redir_valid,
    input  logic [ADDR_W-1:0] main_redir_target,
    input  logic              helper_redir_valid,
    input  logic [ADDR_W-1:0] helper_redir_target,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    output logic [DATA_W-1:0] fetch_word,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_thread
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int NTHR  = FPA_THREADS;

    logic              sel_v [NTHR];
    logic              rv_v  [NTHR];
    logic [ADDR_W-1:0] rt_v  [NTHR];
    logic [ADDR_W-1:0] pc_v  [NTHR];
    logic [ADDR_W-1:0] fetch_pc;
    fpa_thread_e       tag_w;

    assign rv_v[0] = main_redir_valid;
    assign rt_v[0] = main_redir_target;
    assign rv_v[1] = helper_redir_valid;
    assign rt_v[1] = helper_redir_target;

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        localparam int  BASE  = (t == 0) ? 0 : HELPER_BASE;
        localparam int  LIMIT = (t == 0) ? HELPER_BASE - 1 : DEPTH - 1;
        localparam bit  WRAP  = (t != 0);
        fpa_pc_slot #(
            .AW    (ADDR_W),
            .BASE  (BASE),
            .LIMIT (LIMIT),
            .WRAP  (WRAP)
        ) u_slot (
            .clk         (clk),
            .rst         (rst),
            .sel_i       (sel_v[t]),
            .redir_v_i   (rv_v[t]),
            .redir_tgt_i (rt_v[t]),
            .pc_o        (pc_v[t])
        );
    end

    fpa_fetch_sel #(
        .AW          (ADDR_W),
        .HELPER_BASE (HELPER_BASE)
    ) u_sel (
        .clk         (clk),
        .rst         (rst),
        .stall_all_i (stall_all),
        .pc_main_i   (pc_v[0]),
        .pc_help_i   (pc_v[1]),
        .sel_main_o  (sel_v[0]),
        .sel_help_o  (sel_v[1]),
        .fetch_pc_o  (fetch_pc),
        .addr_o      (fetch_addr),
        .tag_o       (tag_w)
    );

    fpa_istore #(
        .AW    (ADDR_W),
        .DW    (DATA_W),
        .DEPTH (DEPTH)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .rd_addr_i (fetch_pc),
        .rd_data_o (fetch_word),
        .wr_en_i   (load_en),
        .wr_addr_i (load_addr),
        .wr_data_i (load_data)
    );

    assign fetch_thread = tag_w;
endmodule

// File: tb/sim_dual_pc_fetch.sv
`timescale 1ns/1ps
module sim_dual_pc_fetch;
    localparam int AW = 10;
    localparam int DW = 46;
    localparam int HB = 768;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          stall_all;
    logic          main_redir_valid;
    logic [AW-1:0] main_redir_target;
    logic          helper_redir_valid;
    logic [AW-1:0] helper_redir_target;
    logic          load_en;
    logic [AW-1:0] load_addr;
    logic [DW-1:0] load_data;
    logic [DW-1:0] fetch_word;
    logic [AW-1:0] fetch_addr;
    logic          fetch_thread;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] mref [DEPTH];
    int mpc, hpc;

    always #5 clk = ~clk;

    dual_pc_fetch u0 (
        .clk(clk), .rst(rst), .stall_all(stall_all),
        .main_redir_valid(main_redir_valid), .main_redir_target(main_redir_target),
        .helper_redir_valid(helper_redir_valid), .helper_redir_target(helper_redir_target),
        .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
        .fetch_word(fetch_word), .fetch_addr(fetch_addr), .fetch_thread(fetch_thread)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int next_pc(int pc, int base, int limit, bit wrap, bit sel, bit rv, int rt);
        if (rv && rt >= base && rt <= limit) return rt;
        if (!sel) return pc;
        if (pc == limit) return wrap ? base : limit;
        return pc + 1;
    endfunction

    function automatic logic [DW-1:0] rnd_word();
        return DW'({$urandom, $urandom});
    endfunction

    // One fetch cycle: drive at negedge, model the edge, compare at next negedge
    task automatic step(input bit st, input bit mv, input int mt, input bit hv, input int ht,
                        input bit we, input int wa, input logic [DW-1:0] wd, input string req);
        int sel_pc;
        logic [DW-1:0] ew;
        stall_all           = st;
        main_redir_valid    = mv;
        main_redir_target   = AW'(mt);
        helper_redir_valid  = hv;
        helper_redir_target = AW'(ht);
        load_en             = we;
        load_addr           = AW'(wa);
        load_data           = wd;
        sel_pc = st ? hpc : mpc;
        ew     = mref[sel_pc];
        if (we) mref[wa] = wd;
        mpc = next_pc(mpc, 0, HB - 1, 1'b0, !st, mv, mt);
        hpc = next_pc(hpc, HB, DEPTH - 1, 1'b1, st, hv, ht);
        @(posedge clk);
        @(negedge clk);
        chk(req, "fetch_addr", 64'(fetch_addr), 64'(sel_pc));
        chk("R7", "fetch_thread", 64'(fetch_thread), 64'(st));
        chk((req == "R11") ? "R11" : "R2", "fetch_word", 64'(fetch_word), 64'(ew));
    endtask

    task automatic run(input bit st, input int n, input string req);
        for (int i = 0; i < n; i++) step(st, 0, 0, 0, 0, 0, 0, '0, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; stall_all = 0; main_redir_valid = 0; main_redir_target = '0;
        helper_redir_valid = 0; helper_redir_target = '0;
        load_en = 0; load_addr = '0; load_data = '0;
        void'($urandom(32'd2024));
        // Load the whole store while reset holds the PCs
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            load_en = 1'b1; load_addr = AW'(a); load_data = rnd_word();
            mref[a] = load_data;
        end
        @(negedge clk);
        load_en = 1'b0;
        @(negedge clk);
        chk("R1", "fetch_addr in reset", 64'(fetch_addr), 64'd0);
        chk("R1", "fetch_thread in reset", 64'(fetch_thread), 64'd0);
        chk("R1", "fetch_word in reset", 64'(fetch_word), 64'd0);
        mpc = 0; hpc = HB;
        rst = 1'b0;

        // R3: main fetches, then helper from its reset point
        run(1'b0, 5, "R3");
        run(1'b1, 4, "R3");
        // R9: main resumes at its held PC (5)
        run(1'b0, 2, "R9");
        // R8: helper redirect while main fetches, then helper near region end
        step(0, 0, 0, 1, 1022, 0, 0, '0, "R8");
        // R6: 1022, 1023, wrap to 768
        run(1'b1, 4, "R6");
        // R8: main redirect while helper fetches
        step(1, 1, 766, 0, 0, 0, 0, '0, "R8");
        // R5: 766, 767, then held at 767
        run(1'b0, 4, "R5");
        // R10: out-of-region targets are ignored
        step(0, 1, 900, 1, 5, 0, 0, '0, "R10");
        step(1, 0, 0, 0, 0, 0, 0, '0, "R10");
        step(0, 1, 10, 0, 0, 0, 0, '0, "R8");
        // R11: write to the address being fetched returns the old word
        step(0, 0, 0, 0, 0, 1, mpc, rnd_word(), "R11");
        step(0, 1, 10, 0, 0, 0, 0, '0, "R8");
        run(1'b0, 2, "R11");

        // R4: random mix of stalls, redirects and loads
        for (int i = 0; i < 600; i++) begin
            bit st, mv, hv, we;
            st = ($urandom_range(0, 99) < 45);
            mv = ($urandom_range(0, 99) < 10);
            hv = ($urandom_range(0, 99) < 10);
            we = ($urandom_range(0, 99) < 20);
            step(st, mv, $urandom_range(0, DEPTH - 1), hv, $urandom_range(0, DEPTH - 1),
                 we, $urandom_range(0, DEPTH - 1), rnd_word(), "R4");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule